// File: doc/BRIEF.md
# Queue condition interrupt generator

This block converts the status flags of a bank of hardware queues into two processor interrupt lines. The queues form a lower group and an upper group of `DATA_W` queues each. For every lower-group queue, a 3-bit code picks one of eight conditions from that queue's empty, nearly-empty, nearly-full and full flags, either as given or inverted. Every upper-group queue always uses its nearly-empty flag.

When the chosen condition of a queue goes from 0 to 1 and the queue's enable bit is 1, the block sets that queue's bit in its group's sticky status register. Software clears status bits by writing ones to them. Each group's interrupt line is high while any bit of its status register is set.

Software reaches the select, enable and status registers through a simple 32-bit word bus. A write is a one-cycle strobe. Read data is combinational on the address. The asynchronous active-low reset is released through a two-stage synchronizer inside the block, so internal state leaves reset on the second rising clock edge after `rst_n` rises.

Top module: `qcond_irq_gen`

## Requirements
- R1: After reset, every register reads 0 and both interrupt lines are low.
- R2: Each lower queue q has a 3-bit select code at word address q/8, bits [4*(q%8)+2 : 4*(q%8)]. The codes are: 0 empty, 1 nearly empty, 2 nearly full, 3 full, 4 not empty, 5 not nearly empty, 6 not nearly full, 7 not full.
- R3: Bit 3 of every 4-bit select field, including queue 0's field in word 0, always reads 0, and writes to it have no effect.
- R4: The condition for upper queue n is always `hi_ne[n]`.
- R5: A status bit is set only in the cycle after its condition rises (0 in one clock edge sample, 1 in the next) while its enable bit is 1. Setting the enable bit while the condition is already high does not set the status bit.
- R6: A status bit stays at 1 after its condition falls, until software clears it.
- R7: A write to a status register clears exactly the bits that are 1 in the write data. All other bits keep their value.
- R8: If a set and a clear hit the same status bit in the same cycle, the bit ends up at 1.
- R9: `irq_lo` and `irq_hi` are high exactly when the lower or upper status register, respectively, is non-zero.
- R10: Word addresses are: 0 to 3 select, 4 lower enable, 5 upper enable, 6 lower status, 7 upper status. Enable registers read back what was written. Addresses 8 to 15 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| lo_e | input | 32 | Empty flags, lower queues |
| lo_ne | input | 32 | Nearly-empty flags, lower queues |
| lo_nf | input | 32 | Nearly-full flags, lower queues |
| lo_f | input | 32 | Full flags, lower queues |
| hi_ne | input | 32 | Nearly-empty flags, upper queues |
| irq_lo | output | 1 | Lower group interrupt |
| irq_hi | output | 1 | Upper group interrupt |

## Verification
The bench walks all eight select codes on queues 0 to 7 and checks the exact status word after each flag transition. A design with a wrong code table or without the inversion would set the wrong bit. It enables a queue while that queue's condition is already high: a design that sets on the level rather than on the edge would raise a false interrupt there. It applies a rising condition and a write-one-to-clear of the same bit in one cycle: a design in which the clear wins would drop the event and leave the line low. It also writes all ones to select word 0 and checks that the reserved bit 3 of every field reads back as 0.

// File: rtl/qirq_pkg.sv
package qirq_pkg;

  // Condition codes for the lower-group select fields
  typedef enum logic [2:0] {
    SRC_E      = 3'd0,
    SRC_NE     = 3'd1,
    SRC_NF     = 3'd2,
    SRC_F      = 3'd3,
    SRC_NOT_E  = 3'd4,
    SRC_NOT_NE = 3'd5,
    SRC_NOT_NF = 3'd6,
    SRC_NOT_F  = 3'd7
  } qsrc_e;

  function automatic logic src_pick(input logic [2:0] code, input logic e,
                                    input logic ne, input logic nf, input logic f);
    logic v;
    case (qsrc_e'(code))
      SRC_E,  SRC_NOT_E:  v = e;
      SRC_NE, SRC_NOT_NE: v = ne;
      SRC_NF, SRC_NOT_NF: v = nf;
      default:            v = f;
    endcase
    return code[2] ? ~v : v;
  endfunction

endpackage

// File: rtl/qirq_srcsel.sv
module qirq_srcsel
  import qirq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] e,
  input  logic [DATA_W-1:0] ne,
  input  logic [DATA_W-1:0] nf,
  input  logic [DATA_W-1:0] f,
  output logic [DATA_W-1:0] cond,
  output logic [DATA_W-1:0] rd_data
);
  localparam int FLD_W  = 4;
  localparam int CODE_W = 3;
  localparam int QPR    = DATA_W / FLD_W;

  logic [CODE_W-1:0] sel_q  [DATA_W];
  logic [CODE_W-1:0] sel_d  [DATA_W];
  logic [DATA_W-1:0] sel_we;

  // next state: field bit 3 is never stored
  always_comb begin
    for (int q = 0; q < DATA_W; q++) begin
      sel_we[q] = wr_en && (addr == ADDR_W'(q / QPR));
      sel_d[q]  = wdata[(q % QPR) * FLD_W +: CODE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int q = 0; q < DATA_W; q++) sel_q[q] <= '0;
    end else begin
      for (int q = 0; q < DATA_W; q++)
        if (sel_we[q]) sel_q[q] <= sel_d[q];
    end
  end

  for (genvar q = 0; q < DATA_W; q++) begin : g_cond
    assign cond[q] = src_pick(sel_q[q], e[q], ne[q], nf[q], f[q]);
  end

  always_comb begin
    rd_data = '0;
    for (int q = 0; q < DATA_W; q++)
      if (addr == ADDR_W'(q / QPR))
        rd_data[(q % QPR) * FLD_W +: CODE_W] = sel_q[q];
  end

endmodule

// File: rtl/qirq_group.sv
module qirq_group #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int EN_ADDR = 4,
  parameter int ST_ADDR = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cond,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic [DATA_W-1:0] en_q, prev_q, stat_q, stat_d;
  logic [DATA_W-1:0] clr_mask, rise_en;
  logic              en_we, stat_we;

  always_comb begin
    en_we    = wr_en && (addr == ADDR_W'(EN_ADDR));
    clr_mask = (wr_en && (addr == ADDR_W'(ST_ADDR))) ? wdata : '0;
    rise_en  = cond & ~prev_q & en_q;
    stat_d   = (stat_q & ~clr_mask) | rise_en;   // set dominates clear
    stat_we  = (|clr_mask) | (|rise_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= cond;
      if (en_we)   en_q   <= wdata;
      if (stat_we) stat_q <= stat_d;
    end
  end

  always_comb begin
    if (addr == ADDR_W'(EN_ADDR))      rd_data = en_q;
    else if (addr == ADDR_W'(ST_ADDR)) rd_data = stat_q;
    else                               rd_data = '0;
  end

  assign irq = |stat_q;

  // R5: an enabled rising condition sets its bit
  a_r5_set_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_en != '0) |=> ((stat_q & $past(rise_en)) == $past(rise_en)));

  // R5: no bit becomes set without an enabled rising condition
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q) & ~$past(rise_en)) == '0));

  // R6: a set bit drops only through a software clear
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((~stat_q & $past(stat_q) & ~$past(clr_mask)) == '0));

  // R7: cleared bits without a coincident set read 0
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask != '0) |=> ((stat_q & $past(clr_mask & ~rise_en)) == '0));

  // R8: set wins over a clear on the same bit
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_mask & rise_en) != '0) |=>
      ((stat_q & $past(clr_mask & rise_en)) == $past(clr_mask & rise_en)));

  // R10: enable register takes the written value
  a_r10_en_write: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> (en_q == $past(wdata)));

endmodule

// File: rtl/qcond_irq_gen.sv
module qcond_irq_gen #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] lo_e,
  input  logic [DATA_W-1:0] lo_ne,
  input  logic [DATA_W-1:0] lo_nf,
  input  logic [DATA_W-1:0] lo_f,
  input  logic [DATA_W-1:0] hi_ne,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam int QPR      = DATA_W / 4;
  localparam int NSEL     = DATA_W / QPR;
  localparam int A_EN_LO  = NSEL;
  localparam int A_EN_HI  = NSEL + 1;
  localparam int A_ST_LO  = NSEL + 2;
  localparam int A_ST_HI  = NSEL + 3;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [DATA_W-1:0] cond_lo, rd_sel, rd_lo, rd_hi;

  qirq_srcsel #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_sel (
    .clk(clk), .rst_n(rst_int_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .e(lo_e), .ne(lo_ne), .nf(lo_nf), .f(lo_f),
    .cond(cond_lo), .rd_data(rd_sel)
  );

  qirq_group #(.DATA_W(DATA_W), .ADDR_W(ADDR_W),
               .EN_ADDR(A_EN_LO), .ST_ADDR(A_ST_LO)) u_lo (
    .clk(clk), .rst_n(rst_int_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .cond(cond_lo), .rd_data(rd_lo), .irq(irq_lo)
  );

  // upper queues: source fixed to nearly-empty
  qirq_group #(.DATA_W(DATA_W), .ADDR_W(ADDR_W),
               .EN_ADDR(A_EN_HI), .ST_ADDR(A_ST_HI)) u_hi (
    .clk(clk), .rst_n(rst_int_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .cond(hi_ne), .rd_data(rd_hi), .irq(irq_hi)
  );

  assign bus_rdata = rd_sel | rd_lo | rd_hi;

endmodule

// File: tb/tb_qcond_irq_gen.sv
module tb_qcond_irq_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] lo_e = '0, lo_ne = '0, lo_nf = '0, lo_f = '0, hi_ne = '0;
  logic        irq_lo, irq_hi;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  qcond_irq_gen dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lo_e(lo_e), .lo_ne(lo_ne), .lo_nf(lo_nf), .lo_f(lo_f), .hi_ne(hi_ne),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  // behavioural reference state
  int          m_sel [32];
  logic [31:0] m_en_lo = '0, m_en_hi = '0, m_st_lo = '0, m_st_hi = '0;
  logic [31:0] m_prev_lo = '0, m_prev_hi = '0;

  function automatic logic m_cond(int q);
    case (m_sel[q])
      0: return lo_e[q];
      1: return lo_ne[q];
      2: return lo_nf[q];
      3: return lo_f[q];
      4: return !lo_e[q];
      5: return !lo_ne[q];
      6: return !lo_nf[q];
      default: return !lo_f[q];
    endcase
  endfunction

  function automatic logic [31:0] m_read(int a);
    logic [31:0] v = '0;
    if (a < 4) begin
      for (int k = 0; k < 8; k++) v[4*k +: 3] = 3'(m_sel[a*8 + k]);
    end else if (a == 4) v = m_en_lo;
    else if (a == 5) v = m_en_hi;
    else if (a == 6) v = m_st_lo;
    else if (a == 7) v = m_st_hi;
    return v;
  endfunction

  task automatic model_step();
    logic [31:0] c = '0, clr_lo = '0, clr_hi = '0;
    for (int q = 0; q < 32; q++) c[q] = m_cond(q);
    if (bus_wr && bus_addr == 4'd6) clr_lo = bus_wdata;
    if (bus_wr && bus_addr == 4'd7) clr_hi = bus_wdata;
    m_st_lo = (m_st_lo & ~clr_lo) | (c & ~m_prev_lo & m_en_lo);
    m_st_hi = (m_st_hi & ~clr_hi) | (hi_ne & ~m_prev_hi & m_en_hi);
    m_prev_lo = c;
    m_prev_hi = hi_ne;
    if (bus_wr) begin
      if (bus_addr < 4)
        for (int k = 0; k < 8; k++) m_sel[bus_addr*8 + k] = int'(bus_wdata[4*k +: 3]);
      else if (bus_addr == 4'd4) m_en_lo = bus_wdata;
      else if (bus_addr == 4'd5) m_en_hi = bus_wdata;
    end
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // one clock: reference updates at the edge, outputs compared mid-low
  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R9 irq_lo", {31'b0, irq_lo}, {31'b0, m_st_lo != 0});
    chk("R9 irq_hi", {31'b0, irq_hi}, {31'b0, m_st_hi != 0});
  endtask

  task automatic wr(int a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
    cyc();
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, logic [31:0] exp, string tag);
    bus_wr = 1'b0; bus_addr = 4'(a);
    #1;
    chk(tag, bus_rdata, exp);
    chk({tag, " model"}, bus_rdata, m_read(a));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int q = 0; q < 32; q++) m_sel[q] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 16; a++) rd(a, 32'h0, "R1 reset read");
    chk("R1 irq_lo", {31'b0, irq_lo}, 32'h0);
    chk("R1 irq_hi", {31'b0, irq_hi}, 32'h0);

    // R3: reserved bit of every field, queue 0 included
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'h7777_7777, "R3 reserved bits");

    // R2: one code per queue 0..7
    wr(0, 32'h7654_3210);
    rd(0, 32'h7654_3210, "R2 select readback");
    wr(4, 32'h0000_00FF);
    rd(4, 32'h0000_00FF, "R10 enable readback");
    lo_e  = 32'hFF; cyc(); rd(6, 32'h01, "R2 code empty");
    lo_ne = 32'hFF; cyc(); rd(6, 32'h03, "R2 code nearly empty");
    lo_nf = 32'hFF; cyc(); rd(6, 32'h07, "R2 code nearly full");
    lo_f  = 32'hFF; cyc(); rd(6, 32'h0F, "R2 code full");
    wr(6, 32'hFF);         rd(6, 32'h00, "R7 clear all");
    lo_e  = 32'h00; cyc(); rd(6, 32'h10, "R2 code not empty");
    lo_ne = 32'h00; cyc(); rd(6, 32'h30, "R2 code not nearly empty");
    lo_nf = 32'h00; cyc(); rd(6, 32'h70, "R2 code not nearly full");
    lo_f  = 32'h00; cyc(); rd(6, 32'hF0, "R6 sticky after fall");
    chk("R9 irq_lo high", {31'b0, irq_lo}, 32'h1);

    // R7: partial clear
    wr(6, 32'h30);         rd(6, 32'hC0, "R7 partial clear");
    wr(6, 32'hC0);         rd(6, 32'h00, "R7 clear rest");
    chk("R9 irq_lo low", {31'b0, irq_lo}, 32'h0);

    // R8: rising edge and clear of queue 0 in the same cycle
    lo_e[0] = 1'b1;
    wr(6, 32'h01);
    rd(6, 32'h01, "R8 set wins");
    wr(6, 32'h01);         rd(6, 32'h00, "R7 clear after R8");

    // R5: enable gating on queue 8 (code 0, empty)
    lo_e[8] = 1'b1; cyc(); lo_e[8] = 1'b0; cyc();
    rd(6, 32'h00, "R5 disabled edge ignored");
    lo_e[8] = 1'b1; cyc();
    wr(4, 32'h0000_01FF); cyc();
    rd(6, 32'h00, "R5 enable while high");
    lo_e[8] = 1'b0; cyc(); lo_e[8] = 1'b1; cyc();
    rd(6, 32'h100, "R5 enabled edge sets");

    // R4: upper group fixed to nearly empty
    lo_ne = '1; lo_nf = '1; lo_f = '1; cyc();
    wr(5, 32'h8);
    rd(7, 32'h0, "R4 other flags no effect");
    hi_ne[3] = 1'b1; cyc();
    rd(7, 32'h8, "R4 upper nearly empty sets");
    chk("R9 irq_hi high", {31'b0, irq_hi}, 32'h1);
    hi_ne[5] = 1'b1; cyc();
    rd(7, 32'h8, "R4 upper disabled bit");
    wr(7, 32'h8);          rd(7, 32'h0, "R7 upper clear");

    // R10: unmapped addresses
    wr(12, 32'hFFFF_FFFF);
    rd(12, 32'h0, "R10 unmapped read");
    rd(4, 32'h0000_01FF, "R10 enable unchanged");
    rd(5, 32'h8, "R10 upper enable readback");

    // mixed traffic against the reference
    for (int i = 0; i < 600; i++) begin
      lo_e = $urandom; lo_ne = $urandom; lo_nf = $urandom; lo_f = $urandom;
      hi_ne = $urandom;
      if ($urandom % 4 == 0) begin
        wr(int'($urandom % 16), $urandom);
      end else begin
        bus_addr = 4'(i % 16);
        #1;
        chk("R10 mixed read", bus_rdata, m_read(i % 16));
        cyc();
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule